// File: doc/BRIEF.md
# Cache Line Coherence State Controller

This block keeps a two-bit coherence state (I, S, E, M) for every line of one cache level. It handles the commands that reach a line from the rest of the hierarchy. Three of them come from the level above: downgrade to shared, invalidate, and forward. The fourth retires a victim line. A fill command installs a state when a line is brought in. The block accepts one command at a time. Fill, downgrade, invalidate, forward, and any eviction that needs no parent traffic each finish one cycle after acceptance. At that point the block pulses `done`, together with `wb_req` if the line held modified data that must be written back, and `err` if the command was illegal for the line's state.

An eviction of a valid line sends a put request to the parent level. The put is clean if the line held S or E and dirty if it held M. If the level below reports that it wrote data back on this eviction, the line is first promoted from E to M, so the put goes out dirty. The request uses a valid/ready handshake. After the parent accepts it, the block waits for a one-cycle response pulse, then sets the line to I and reports `done`. While an eviction is in flight, `busy` is high and `cmd_ready` is low.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is in state I, `cmd_ready` is 1, and `put_valid`, `done`, `err`, `wb_req` and `busy` are 0.
- R2: State codes are I=0, S=1, E=2, M=3. Command codes on `cmd_op` are fill=0, downgrade=1, invalidate=2, forward=3, evict=4. A fill writes `cmd_state` into the indexed line and never flags an error.
- R3: A downgrade of a line in E or M moves it to S and raises `wb_req` only when the old state was M. A downgrade of a line in S or I raises `err` and leaves the line unchanged.
- R4: An invalidate of a line in S, E or M moves it to I and raises `wb_req` only when the old state was M. An invalidate of a line in I raises `err`.
- R5: A forward of a line in S leaves the state unchanged and raises neither `wb_req` nor `err`. A forward of a line in any other state raises `err` and changes nothing.
- R6: Evicting a line in S or E issues a put with `put_dirty`=0. Evicting a line in M issues a put with `put_dirty`=1. Evicting a line in I issues no put and completes one cycle after acceptance.
- R7: An eviction with `cmd_lower_wb`=1 of a line in E or M issues a dirty put. With `cmd_lower_wb`=1 on a line in S or I, `err` is raised and the eviction proceeds according to the line's own state.
- R8: `put_valid` stays high with `put_addr` and `put_dirty` unchanged until `put_ready` is sampled high. After that, the block waits for `put_resp`. `done` rises in the cycle after `put_resp` is sampled, and the evicted line is then in I.
- R9: From the acceptance of an eviction that issues a put until its `done`, `busy` is 1 and `cmd_ready` is 0. Commands presented during that time are ignored.
- R10: `done` is a one-cycle pulse per accepted command. `err` and `wb_req` are 0 whenever `done` is 0.
- R11: Command codes 5, 6 and 7 raise `err` and change no line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command code |
| cmd_idx | input | $clog2(LINES) | Line index |
| cmd_addr | input | AW | Line address used for the put |
| cmd_state | input | 2 | State written by a fill |
| cmd_lower_wb | input | 1 | Lower level wrote back during this eviction |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Illegal command for the line state, valid with done |
| wb_req | output | 1 | Modified data must be written back, valid with done |
| busy | output | 1 | Eviction in flight |
| put_valid | output | 1 | Put request to parent |
| put_ready | input | 1 | Parent accepts put |
| put_addr | output | AW | Put line address |
| put_dirty | output | 1 | 1 for a dirty put, 0 for a clean put |
| put_resp | input | 1 | Parent response pulse |

## Verification
The handshake assertions assume that the parent pulses `put_resp` only while the block is waiting after an accepted put, and that the parent never responds to a put it has not accepted. The bench's parent model raises `put_ready` and `put_resp` only at those points, and it holds each of them for exactly one cycle. The assertions also assume that `cmd_idx` is below `LINES`. The bench only draws indices in that range. Commands offered during an eviction are legal input and are driven on purpose to show that they are ignored.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int LINES = 16,
  parameter int AW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_op,
  input  logic [$clog2(LINES)-1:0] cmd_idx,
  input  logic [AW-1:0]            cmd_addr,
  input  logic [1:0]               cmd_state,
  input  logic                     cmd_lower_wb,
  output logic                     done,
  output logic                     err,
  output logic                     wb_req,
  output logic                     busy,
  output logic                     put_valid,
  input  logic                     put_ready,
  output logic [AW-1:0]            put_addr,
  output logic                     put_dirty,
  input  logic                     put_resp
);
  localparam int IW = $clog2(LINES);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [2:0] OP_FILL = 3'd0, OP_DOWN = 3'd1, OP_INV = 3'd2,
                         OP_FWD = 3'd3, OP_EVICT = 3'd4;

  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT} phase_t;

  logic [1:0] lines [LINES];
  phase_t     ph;
  logic [IW-1:0] ev_idx;
  logic       ev_err;

  logic       acc;
  logic [1:0] cur, nxt, eff;
  logic       upd, x_err, x_wb, x_put;

  assign cmd_ready = (ph == PH_IDLE);
  assign busy      = (ph != PH_IDLE);
  assign put_valid = (ph == PH_REQ);
  assign acc       = cmd_valid && cmd_ready;
  assign cur       = lines[cmd_idx];

  always_comb begin
    nxt   = cur;
    upd   = 1'b0;
    x_err = 1'b0;
    x_wb  = 1'b0;
    x_put = 1'b0;
    eff   = cur;
    unique case (cmd_op)
      OP_FILL: begin
        nxt = cmd_state;
        upd = 1'b1;
      end
      OP_DOWN: begin
        if (cur == ST_E || cur == ST_M) begin
          nxt  = ST_S;
          upd  = 1'b1;
          x_wb = (cur == ST_M);
        end else x_err = 1'b1;
      end
      OP_INV: begin
        if (cur != ST_I) begin
          nxt  = ST_I;
          upd  = 1'b1;
          x_wb = (cur == ST_M);
        end else x_err = 1'b1;
      end
      OP_FWD: x_err = (cur != ST_S);
      OP_EVICT: begin
        if (cmd_lower_wb) begin
          if (cur == ST_E || cur == ST_M) eff = ST_M;
          else x_err = 1'b1;
        end
        x_put = (eff != ST_I);
      end
      default: x_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) lines[i] <= ST_I;
      ph        <= PH_IDLE;
      ev_idx    <= '0;
      ev_err    <= 1'b0;
      put_addr  <= '0;
      put_dirty <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      wb_req    <= 1'b0;
    end else begin
      done   <= 1'b0;
      err    <= 1'b0;
      wb_req <= 1'b0;
      unique case (ph)
        PH_IDLE: if (acc) begin
          if (upd) lines[cmd_idx] <= nxt;
          if (x_put) begin
            ph        <= PH_REQ;
            ev_idx    <= cmd_idx;
            ev_err    <= x_err;
            put_addr  <= cmd_addr;
            put_dirty <= (eff == ST_M);
          end else begin
            done   <= 1'b1;
            err    <= x_err;
            wb_req <= x_wb;
          end
        end
        PH_REQ: if (put_ready) ph <= PH_WAIT;
        PH_WAIT: if (put_resp) begin
          lines[ev_idx] <= ST_I;
          ph   <= PH_IDLE;
          done <= 1'b1;
          err  <= ev_err;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  p_put_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    put_valid && !put_ready |=> put_valid && $stable(put_addr) && $stable(put_dirty));

  p_evict_final_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WAIT) && put_resp |=> done && lines[ev_idx] == ST_I && !busy);

  p_inv_to_i_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == OP_INV |=> lines[$past(cmd_idx)] == ST_I);

  p_wb_only_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == OP_DOWN || cmd_op == OP_INV) && cur != ST_M |=> !wb_req);

  p_fwd_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == OP_FWD |=> lines[$past(cmd_idx)] == $past(cur));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_flags_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !err && !wb_req);

  p_busy_no_put_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    put_valid |-> !done && !cmd_ready);
endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
  localparam int LINES = 16;
  localparam int AW    = 32;
  localparam int IW    = $clog2(LINES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready, cmd_lower_wb = 0;
  logic [2:0] cmd_op = 0;
  logic [IW-1:0] cmd_idx = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [1:0] cmd_state = 0;
  logic done, err, wb_req, busy, put_valid, put_dirty;
  logic put_ready = 0, put_resp = 0;
  logic [AW-1:0] put_addr;

  int checks = 0, errors = 0;
  int mdl [LINES];
  bit ended = 0;

  always #5 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_addr(cmd_addr), .cmd_state(cmd_state),
    .cmd_lower_wb(cmd_lower_wb), .done(done), .err(err), .wb_req(wb_req), .busy(busy),
    .put_valid(put_valid), .put_ready(put_ready), .put_addr(put_addr),
    .put_dirty(put_dirty), .put_resp(put_resp));

  task automatic chk(input longint act, input longint exp, input string rq, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(input int idx);
    return 32'h4000 + idx * 64;
  endfunction

  task automatic do_cmd(input logic [2:0] op, input int idx, input logic [1:0] st,
                        input logic lwb, input int rdly, input int pdly);
    int s = mdl[idx];
    int e = s;
    bit xe = 0, xw = 0;
    int xp = 0;
    string rq;
    case (op)
      0: begin rq = "R2"; mdl[idx] = st; end
      1: begin rq = "R3"; if (s >= 2) begin xw = (s == 3); mdl[idx] = 1; end else xe = 1; end
      2: begin rq = "R4"; if (s != 0) begin xw = (s == 3); mdl[idx] = 0; end else xe = 1; end
      3: begin rq = "R5"; xe = (s != 1); end
      4: begin
        rq = lwb ? "R7" : "R6";
        if (lwb) begin if (s >= 2) e = 3; else xe = 1; end
        xp = (e == 0) ? 0 : (e == 3) ? 2 : 1;
        mdl[idx] = 0;
      end
      default: begin rq = "R11"; xe = 1; end
    endcase
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_idx = IW'(idx); cmd_state = st;
    cmd_lower_wb = lwb; cmd_addr = addr_of(idx);
    @(posedge clk); #2;
    cmd_valid = 0;
    if (xp == 0) begin
      chk(put_valid, 0, rq, "no put");
      chk(done, 1, rq, "done");
      chk(err, xe, rq, "err");
      chk(wb_req, xw, rq, "wb_req");
    end else begin
      chk(put_valid, 1, "R8", "put_valid");
      chk(put_dirty, xp == 2, rq, "put_dirty");
      chk(put_addr, addr_of(idx), "R8", "put_addr");
      chk(cmd_ready, 0, "R9", "cmd_ready low");
      chk(busy, 1, "R9", "busy");
      chk(done, 0, "R10", "no early done");
      for (int k = 0; k < rdly; k++) begin
        if (k == 0) begin
          cmd_valid = 1; cmd_op = 0; cmd_idx = IW'(idx ^ 1); cmd_state = 2'd3;
        end
        @(posedge clk); #2;
        cmd_valid = 0;
        chk(put_valid, 1, "R8", "put held");
        chk(put_dirty, xp == 2, "R8", "dirty held");
        chk(put_addr, addr_of(idx), "R8", "addr held");
      end
      put_ready = 1;
      @(posedge clk); #2;
      put_ready = 0;
      chk(put_valid, 0, "R8", "put dropped");
      chk(busy, 1, "R9", "busy waiting");
      for (int k = 0; k < pdly; k++) begin
        @(posedge clk); #2;
        chk(done, 0, "R8", "wait resp");
      end
      put_resp = 1;
      @(posedge clk); #2;
      put_resp = 0;
      chk(done, 1, "R8", "done after resp");
      chk(err, xe, rq, "err");
      chk(wb_req, 0, "R10", "wb_req");
      chk(busy, 0, "R9", "busy clear");
      chk(cmd_ready, 1, "R9", "ready back");
    end
    @(posedge clk); #2;
    chk(done, 0, "R10", "done one cycle");
    chk(err, 0, "R10", "err low");
  endtask

  initial begin
    #2000000;
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    chk(cmd_ready, 1, "R1", "ready");
    chk(put_valid, 0, "R1", "put_valid");
    chk(done, 0, "R1", "done");
    chk(busy, 0, "R1", "busy");
    chk(err, 0, "R1", "err");
    chk(wb_req, 0, "R1", "wb_req");
    for (int i = 0; i < 4; i++) do_cmd(3'd4, i, 0, 0, 0, 0);

    do_cmd(0, 0, 2, 0, 0, 0); do_cmd(0, 1, 3, 0, 0, 0);
    do_cmd(0, 2, 1, 0, 0, 0); do_cmd(0, 3, 0, 0, 0, 0);
    do_cmd(1, 0, 0, 0, 0, 0); do_cmd(1, 1, 0, 0, 0, 0);
    do_cmd(1, 2, 0, 0, 0, 0); do_cmd(1, 3, 0, 0, 0, 0);

    do_cmd(0, 4, 3, 0, 0, 0); do_cmd(2, 4, 0, 0, 0, 0);
    do_cmd(2, 0, 0, 0, 0, 0); do_cmd(2, 4, 0, 0, 0, 0);
    do_cmd(0, 12, 2, 0, 0, 0); do_cmd(2, 12, 0, 0, 0, 0);

    do_cmd(3, 1, 0, 0, 0, 0); do_cmd(3, 4, 0, 0, 0, 0);
    do_cmd(0, 5, 2, 0, 0, 0); do_cmd(3, 5, 0, 0, 0, 0);

    do_cmd(4, 1, 0, 0, 3, 2);
    do_cmd(4, 0, 0, 0, 0, 0);
    do_cmd(0, 6, 2, 0, 0, 0); do_cmd(4, 6, 0, 0, 0, 0);
    do_cmd(0, 7, 3, 0, 0, 0); do_cmd(4, 7, 0, 0, 1, 4);

    do_cmd(0, 8, 2, 0, 0, 0); do_cmd(4, 8, 0, 1, 0, 1);
    do_cmd(0, 9, 1, 0, 0, 0); do_cmd(4, 9, 0, 1, 2, 0);
    do_cmd(4, 10, 0, 1, 0, 0);
    do_cmd(0, 11, 3, 0, 0, 0); do_cmd(4, 11, 0, 1, 0, 0);

    do_cmd(5, 5, 0, 0, 0, 0); do_cmd(6, 5, 0, 0, 0, 0); do_cmd(7, 5, 0, 0, 0, 0);
    do_cmd(4, 5, 0, 0, 0, 0);

    for (int i = 0; i < LINES; i++) do_cmd(4, i, 0, 0, 0, 0);

    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule